// File: doc/BRIEF.md
# Bidirectional Latched/Clocked Bus Transceiver

This block joins two parallel buses, port A and port B, through two independent one-way paths: A-to-B and B-to-A. Each path holds one storage word per direction. That word is shared by every bit lane of the path, and its behaviour is chosen by two control inputs. While the hold-select input is high, the word follows the source bus. While it is low, the word loads the source bus only on a rising transition of the path's capture strobe, and otherwise keeps its value. Each destination port has its own enable. The A-to-B enable is active high and the B-to-A enable is active low.

Tri-state pins are modelled as a data bus plus a drive flag. When a port is not driven, its flag is low and its data bus reads zero. A wrapper at the chip pads can map each pair onto an inout wire. All logic runs on one system clock. The capture strobes are sampled as ordinary signals, and their rising transitions are found by comparing each sample with the one taken a cycle earlier. Every output is registered, so a change at the inputs appears on the outputs one system clock later.

Top module: `bus_xcvr`

## Requirements
- R1: `b_drive` equals the value `ab_oe` had one cycle earlier. Whenever `b_drive` is 0, `b_out` is all zeros.
- R2: `a_drive` equals the inverse of the value `ba_oe_n` had one cycle earlier. Whenever `a_drive` is 0, `a_out` is all zeros.
- R3: While `ab_le` is 1 and `ab_oe` is 1, `b_out` one cycle later equals `a_in`, whatever `ab_strobe` does.
- R4: While `ab_le` is 0, a cycle where `ab_strobe` is 1 after being 0 in the previous cycle loads `a_in` into the A-to-B word. If `ab_oe` is 1, that value is on `b_out` one cycle later.
- R5: While `ab_le` is 0 and `ab_strobe` shows no rising transition, the A-to-B word keeps its value. This holds with the strobe steady high or steady low, and it applies to the last value that passed through while `ab_le` was 1.
- R6: The B-to-A path follows R3, R4 and R5, using `ba_le`, `ba_strobe` and `b_in`, and drives `a_out`.
- R7: If a path's hold-select falls in the same cycle that its strobe rises, the word loads the source value present in that cycle.
- R8: The storage words keep updating while their port is not driven. Re-enabling a port shows the current word one cycle after the enable.
- R9: A synchronous active-high `rst` clears both words, both data outputs and both drive flags. A strobe held high through reset and after it does not count as a rising transition.
- R10: The two paths are independent. Controls of one direction never change the other direction's word or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Source bus sampled from port A |
| ab_oe | input | 1 | Port B drive enable, active high |
| ab_le | input | 1 | A-to-B hold-select: 1 follows, 0 strobe-loaded |
| ab_strobe | input | 1 | A-to-B capture strobe, rising transition loads |
| b_out | output | W | Data presented at port B |
| b_drive | output | 1 | Port B is driven (0 stands for high impedance) |
| b_in | input | W | Source bus sampled from port B |
| ba_oe_n | input | 1 | Port A drive enable, active low |
| ba_le | input | 1 | B-to-A hold-select |
| ba_strobe | input | 1 | B-to-A capture strobe |
| a_out | output | W | Data presented at port A |
| a_drive | output | 1 | Port A is driven |

## Verification
The bench targets several corner cases.

- **Hold after hold-select falls, strobe steady high and steady low.** A design that confuses a high strobe level with an edge would reload on every cycle while the strobe stays high.
- **Hold-select falling in the same cycle the strobe rises.** A design that gave the latch-close priority over the edge would keep the older word.
- **Disabled ports while data arrives.** A design that gated storage with the enable would show stale data on re-enable. Swapped enable polarities would drive the wrong port.
- **Strobe held high across reset release.** A design whose edge detector reset to zero would capture spuriously.

Long random runs, with both directions active together, expose any crosstalk between the paths.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP    = 2'd0,
    ACT_FOLLOW  = 2'd1,
    ACT_CAPTURE = 2'd2
  } store_act_t;

  // Follow mode wins over the strobe; with follow off only an edge loads.
  function automatic store_act_t pick_action(input logic follow, input logic edge_seen);
    if (follow)         return ACT_FOLLOW;
    else if (edge_seen) return ACT_CAPTURE;
    else                return ACT_KEEP;
  endfunction

endpackage

// File: rtl/bus_xcvr_edge.sv
module bus_xcvr_edge (
  input  logic clk,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  // Tracks the strobe even during reset so release never fakes an edge.
  always_ff @(posedge clk) begin
    strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/bus_xcvr_store.sv
module bus_xcvr_store
  import bus_xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  store_act_t   act,
  input  logic [W-1:0] d,
  output logic [W-1:0] word_next
);
  logic [W-1:0] word_q;

  always_comb begin
    case (act)
      ACT_FOLLOW, ACT_CAPTURE: word_next = d;
      default:                 word_next = word_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= word_next;
  end
endmodule

// File: rtl/bus_xcvr_drive.sv
module bus_xcvr_drive #(
  parameter int W       = 18,
  parameter bit OE_HIGH = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_pin,
  input  logic [W-1:0] word,
  output logic [W-1:0] dout,
  output logic         drive
);
  localparam logic [W-1:0] IDLE_VAL = '0;
  logic en;

  generate
    if (OE_HIGH) begin : g_pos
      assign en = oe_pin;
    end else begin : g_neg
      assign en = ~oe_pin;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= IDLE_VAL;
      drive <= 1'b0;
    end else begin
      dout  <= en ? word : IDLE_VAL;
      drive <= en;
    end
  end
endmodule

// File: rtl/bus_xcvr_path.sv
module bus_xcvr_path
  import bus_xcvr_pkg::*;
#(
  parameter int W       = 18,
  parameter bit OE_HIGH = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic         oe_pin,
  input  logic         follow,
  input  logic         strobe,
  output logic [W-1:0] dst,
  output logic         dst_drive
);
  logic         rise;
  store_act_t   act;
  logic [W-1:0] word_next;

  bus_xcvr_edge u_edge (
    .clk    (clk),
    .strobe (strobe),
    .rise   (rise)
  );

  assign act = pick_action(follow, rise);

  bus_xcvr_store #(.W(W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .d         (src),
    .word_next (word_next)
  );

  bus_xcvr_drive #(.W(W), .OE_HIGH(OE_HIGH)) u_drive (
    .clk    (clk),
    .rst    (rst),
    .oe_pin (oe_pin),
    .word   (word_next),
    .dout   (dst),
    .drive  (dst_drive)
  );
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         ab_oe,
  input  logic         ab_le,
  input  logic         ab_strobe,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  input  logic [W-1:0] b_in,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_strobe,
  output logic [W-1:0] a_out,
  output logic         a_drive
);
  // A-to-B: enable active high; B-to-A: enable active low.
  bus_xcvr_path #(.W(W), .OE_HIGH(1'b1)) u_ab (
    .clk       (clk),
    .rst       (rst),
    .src       (a_in),
    .oe_pin    (ab_oe),
    .follow    (ab_le),
    .strobe    (ab_strobe),
    .dst       (b_out),
    .dst_drive (b_drive)
  );

  bus_xcvr_path #(.W(W), .OE_HIGH(1'b0)) u_ba (
    .clk       (clk),
    .rst       (rst),
    .src       (b_in),
    .oe_pin    (ba_oe_n),
    .follow    (ba_le),
    .strobe    (ba_strobe),
    .dst       (a_out),
    .dst_drive (a_drive)
  );
endmodule

// File: rtl/bus_xcvr_checks.sv
module bus_xcvr_checks #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic         ab_oe,
  input logic         ab_le,
  input logic         ab_strobe,
  input logic [W-1:0] b_out,
  input logic         b_drive,
  input logic [W-1:0] b_in,
  input logic         ba_oe_n,
  input logic         ba_le,
  input logic         ba_strobe,
  input logic [W-1:0] a_out,
  input logic         a_drive
);
  a_r1_b_flag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (b_drive == $past(ab_oe)));
  a_r1_b_quiet: assert property (@(posedge clk) disable iff (rst)
    !b_drive |-> (b_out == '0));
  a_r2_a_flag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (a_drive == !$past(ba_oe_n)));
  a_r2_a_quiet: assert property (@(posedge clk) disable iff (rst)
    !a_drive |-> (a_out == '0));
  a_r3_follow: assert property (@(posedge clk) disable iff (rst)
    (ab_le && ab_oe) |=> (b_out == $past(a_in)));
  a_r4_capture: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && ab_oe && ab_strobe && !$past(ab_strobe)) |=> (b_out == $past(a_in)));
  a_r5_keep: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && ab_oe && b_drive && !(ab_strobe && !$past(ab_strobe))) |=> $stable(b_out));
  a_r6_follow: assert property (@(posedge clk) disable iff (rst)
    (ba_le && !ba_oe_n) |=> (a_out == $past(b_in)));
  a_r6_keep: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && !ba_oe_n && a_drive && !(ba_strobe && !$past(ba_strobe))) |=> $stable(a_out));
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (!b_drive && !a_drive && b_out == '0 && a_out == '0));
endmodule

bind bus_xcvr bus_xcvr_checks #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .a_in(a_in), .ab_oe(ab_oe), .ab_le(ab_le),
  .ab_strobe(ab_strobe), .b_out(b_out), .b_drive(b_drive), .b_in(b_in),
  .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_strobe(ba_strobe),
  .a_out(a_out), .a_drive(a_drive)
);

// File: tb/bus_xcvr_tb_top.sv
module bus_xcvr_tb_top;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_oe = 1'b0, ab_le = 1'b0, ab_strobe = 1'b0;
  logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_strobe = 1'b0;
  logic [W-1:0] b_out, a_out;
  logic b_drive, a_drive;

  always #4 clk = ~clk;

  bus_xcvr #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .ab_oe(ab_oe), .ab_le(ab_le),
    .ab_strobe(ab_strobe), .b_out(b_out), .b_drive(b_drive), .b_in(b_in),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_strobe(ba_strobe),
    .a_out(a_out), .a_drive(a_drive)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Behavioural reference state.
  logic [W-1:0] m_ab_word = '0, m_ba_word = '0;
  logic m_ab_prev = 1'b0, m_ba_prev = 1'b0;
  logic [W-1:0] e_b = '0, e_a = '0;
  logic e_bd = 1'b0, e_ad = 1'b0;
  bit primed = 0;

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag,
                      logic [W-1:0] na, logic noe, logic nle, logic nst,
                      logic [W-1:0] nb, logic noen, logic nle2, logic nst2,
                      logic nrst);
    @(negedge clk);
    if (primed) begin
      check(tag, "b_out",   b_out, e_b);
      check(tag, "b_drive", {{(W-1){1'b0}}, b_drive}, {{(W-1){1'b0}}, e_bd});
      check(tag, "a_out",   a_out, e_a);
      check(tag, "a_drive", {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, e_ad});
    end
    a_in = na; ab_oe = noe; ab_le = nle; ab_strobe = nst;
    b_in = nb; ba_oe_n = noen; ba_le = nle2; ba_strobe = nst2; rst = nrst;
    // Predict the state after the coming rising edge.
    if (nrst) begin
      m_ab_word = '0; m_ba_word = '0;
      e_b = '0; e_a = '0; e_bd = 0; e_ad = 0;
    end else begin
      if (nle || (nst && !m_ab_prev)) m_ab_word = na;
      if (nle2 || (nst2 && !m_ba_prev)) m_ba_word = nb;
      e_bd = noe;   e_b = noe ? m_ab_word : '0;
      e_ad = !noen; e_a = !noen ? m_ba_word : '0;
    end
    m_ab_prev = nst; m_ba_prev = nst2;
    primed = 1;
  endtask

  task automatic ab(string tag, logic [W-1:0] na, logic noe, logic nle, logic nst);
    step(tag, na, noe, nle, nst, b_in, ba_oe_n, ba_le, ba_strobe, 1'b0);
  endtask

  task automatic ba(string tag, logic [W-1:0] nb, logic noen, logic nle, logic nst);
    step(tag, a_in, ab_oe, ab_le, ab_strobe, nb, noen, nle, nst, 1'b0);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    // R9: reset with strobes held high through release, enables on.
    for (int i = 0; i < 3; i++)
      step("R9", 18'h155AA, 1, 0, 1, 18'h2AA55, 0, 0, 1, 1'b1);
    for (int i = 0; i < 3; i++)
      step("R9", 18'h3FFFF, 1, 0, 1, 18'h3FFFF, 0, 0, 1, 1'b0);
    // R1: disabled B port reads zero, then enabled follow.
    ab("R1", 18'h12345, 0, 1, 0);
    ab("R1", 18'h0BEEF, 0, 1, 0);
    ab("R1", 18'h0BEEF, 1, 1, 0);
    ab("R3", 18'h0F0F0, 1, 1, 1);
    ab("R3", 18'h30303, 1, 1, 0);
    ab("R3", 18'h3C3C3, 1, 1, 1);
    // R5: close latch with strobe high, then hold high and low.
    ab("R5", 18'h11111, 1, 0, 1);
    ab("R5", 18'h22222, 1, 0, 1);
    ab("R5", 18'h33333, 1, 0, 0);
    ab("R5", 18'h04444, 1, 0, 0);
    // R4: rising strobe loads.
    ab("R4", 18'h05555, 1, 0, 1);
    ab("R4", 18'h06666, 1, 0, 1);
    ab("R4", 18'h07777, 1, 0, 0);
    ab("R4", 18'h08888, 1, 0, 1);
    // R7: latch closes in the same cycle the strobe rises.
    ab("R7", 18'h01010, 1, 1, 0);
    ab("R7", 18'h2ABCD, 1, 0, 1);
    ab("R7", 18'h00001, 1, 0, 1);
    // R8: load while disabled, then reveal.
    ab("R8", 18'h09999, 0, 0, 0);
    ab("R8", 18'h1ACE1, 0, 0, 1);
    ab("R8", 18'h00002, 0, 0, 1);
    ab("R8", 18'h00003, 1, 0, 1);
    // R2 / R6: B-to-A path with active-low enable.
    ba("R2", 18'h13579, 1, 1, 0);
    ba("R2", 18'h13579, 0, 1, 0);
    ba("R6", 18'h2468A, 0, 1, 1);
    ba("R6", 18'h0DEAD, 0, 0, 1);
    ba("R6", 18'h0FACE, 0, 0, 0);
    ba("R6", 18'h1F00D, 0, 0, 1);
    ba("R7", 18'h0C0DE, 0, 1, 0);
    ba("R7", 18'h3ABBA, 0, 0, 1);
    ba("R8", 18'h01234, 1, 0, 0);
    ba("R8", 18'h05678, 1, 0, 1);
    ba("R8", 18'h00000, 0, 0, 1);
    // R10: both directions randomly and together.
    for (int i = 0; i < 3000; i++)
      step("R10", W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  ($urandom % 200) == 0);
    step("R10", a_in, ab_oe, ab_le, ab_strobe, b_in, ba_oe_n, ba_le, ba_strobe, 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule